// File: doc/BRIEF.md
# Subtract Instruction Execute Unit

This block executes two 8-bit subtract instructions for an accumulator-style microcontroller core. One form subtracts the working register W from an 8-bit literal carried in the instruction word. The other form subtracts W from a byte in a small banked data memory. In both forms W is the subtrahend. The block decodes the instruction and fetches the operand. It forms the difference and five status flags, then writes the result to W or back to the data byte.

Every instruction runs over a fixed cycle of four clock phases that repeats from reset: decode, operand read, process, write. A core puts an instruction word on `instr_i` during the decode phase. All architectural state changes on the clock edge that ends the write phase. For the register form, the data address comes from the instruction's file address. A bank-select bit in the instruction picks how the upper address bits are made: from the core's bank register, or from a fixed access mapping. The core's other instructions reach the data memory and W through a plain host port. A word that is neither subtract form leaves all state alone.

Top module: `sub_exec_unit`

## Requirements
- R1: `phase_o` starts at 0 after reset and counts 0,1,2,3,0,... one step per clock. 0 is decode, 1 is operand read, 2 is process and 3 is write.
- R2: A word with bits [15:8] = 0x08 is the literal form. It sets W to (bits [7:0] − W) modulo 256.
- R3: A word with bits [15:10] = 6'b010111 is the register form. Bit 9 is the destination bit d, bit 8 is the bank bit a and bits [7:0] are the file address f. With d=0 the result (mem − W) goes to W and the data byte is left unchanged.
- R4: With d=1 the result is written to the addressed data byte and W keeps its value.
- R5: With a=0 the data address is {4'h0,f} for f < 0x80 and {4'hF,f} for f ≥ 0x80. `bsr_i` is ignored.
- R6: With a=1 the data address is {bsr_i,f}. `bsr_i` is sampled together with the instruction word.
- R7: After either subtract, C (`status_o[0]`) is 1 exactly when the minuend ≥ W as unsigned numbers. Z (`status_o[2]`) is 1 exactly when the result is zero.
- R8: N (`status_o[4]`) equals result bit 7. OV (`status_o[3]`) is 1 exactly when the signed difference falls outside −128..127.
- R9: DC (`status_o[1]`) is 1 exactly when minuend[3:0] ≥ W[3:0], meaning no borrow out of the low nibble.
- R10: Any other instruction word leaves W, the status bits and the data memory unchanged.
- R11: After reset, W and `status_o` read zero.
- R12: The instruction word is sampled on the edge that ends phase 0. W, the status bits and the data byte update only on the edge that ends phase 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word, sampled at the end of phase 0 |
| bsr_i | input | 4 | Bank number from the core, sampled with the instruction |
| w_we_i | input | 1 | Host load of W |
| w_wdata_i | input | 8 | Host data for W |
| rf_we_i | input | 1 | Host write to data memory |
| rf_addr_i | input | 12 | Host data-memory address |
| rf_wdata_i | input | 8 | Host write data |
| rf_rdata_o | output | 8 | Data memory contents at rf_addr_i |
| w_o | output | 8 | Working register |
| status_o | output | 5 | {N, OV, Z, DC, C} |
| phase_o | output | 2 | Current phase, 0 to 3 |

## Verification
The bench drives each of the three sign outcomes. A design with inverted borrow polarity would clear C on a positive or zero result. A design that swaps the operands would give 0x01 where 0xFF is expected. Nibble-borrow and signed-overflow pairs are chosen so that DC and OV disagree with C. A design that copies C into DC, or takes OV from the carry, is caught this way. For the register form, the bench preloads the byte at the alternative bank mapping and checks that it keeps its value. A design that mixes up the meaning of a, or of d, writes the wrong byte or the wrong destination. The bench also checks W one phase before the write edge, which catches an early write-back.

// File: rtl/sub_exec_pkg.sv
package sub_exec_pkg;
  localparam int DATA_W  = 8;
  localparam int BANK_W  = 4;
  localparam int ADDR_W  = BANK_W + DATA_W;
  localparam int INSTR_W = 16;
  localparam int NFLAGS  = 5;

  localparam int FLAG_C  = 0;
  localparam int FLAG_DC = 1;
  localparam int FLAG_Z  = 2;
  localparam int FLAG_OV = 3;
  localparam int FLAG_N  = 4;

  localparam logic [7:0] LIT_OPC = 8'h08;
  localparam logic [5:0] REG_OPC = 6'b010111;

  typedef enum logic [1:0] {
    PH_DEC  = 2'd0,
    PH_READ = 2'd1,
    PH_PROC = 2'd2,
    PH_WR   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LIT  = 2'd1,
    OP_REG  = 2'd2
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              to_file;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] lit;
  } dec_t;
endpackage

// File: rtl/sub_phase_gen.sv
module sub_phase_gen
  import sub_exec_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_o
);
  phase_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_DEC;
    else begin
      unique case (phase_q)
        PH_DEC:  phase_q <= PH_READ;
        PH_READ: phase_q <= PH_PROC;
        PH_PROC: phase_q <= PH_WR;
        default: phase_q <= PH_DEC;
      endcase
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/sub_decoder.sv
module sub_decoder
  import sub_exec_pkg::*;
#(
  parameter logic [DATA_W-1:0] ACC_SPLIT = 8'h80,
  parameter logic [BANK_W-1:0] ACC_LO_BANK = '0,
  parameter logic [BANK_W-1:0] ACC_HI_BANK = '1
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [BANK_W-1:0]  bsr_i,
  output dec_t               dec_o
);
  logic [DATA_W-1:0] f;
  logic              bit_d;
  logic              bit_a;
  logic [BANK_W-1:0] bank;

  assign f     = instr_i[DATA_W-1:0];
  assign bit_d = instr_i[9];
  assign bit_a = instr_i[8];

  always_comb begin
    if (bit_a)              bank = bsr_i;
    else if (f < ACC_SPLIT) bank = ACC_LO_BANK;
    else                    bank = ACC_HI_BANK;
  end

  always_comb begin
    dec_o.op      = OP_NONE;
    dec_o.to_file = 1'b0;
    dec_o.addr    = {bank, f};
    dec_o.lit     = f;
    if (instr_i[15:8] == LIT_OPC) begin
      dec_o.op = OP_LIT;
    end else if (instr_i[15:10] == REG_OPC) begin
      dec_o.op      = OP_REG;
      dec_o.to_file = bit_d;
    end
  end
endmodule

// File: rtl/sub_alu.sv
module sub_alu
  import sub_exec_pkg::*;
#(
  parameter int NIB_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] min_i,
  input  logic [DATA_W-1:0] sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NFLAGS-1:0] flags_o
);
  logic [DATA_W:0] full_sum;
  logic [NIB_W:0]  nib_sum;
  logic [DATA_W-1:0] sub_n;

  assign sub_n    = ~sub_i;
  // minuend + ~W + 1; carry out means no borrow
  assign full_sum = {1'b0, min_i} + {1'b0, sub_n} + {{DATA_W{1'b0}}, 1'b1};
  assign nib_sum  = {1'b0, min_i[NIB_W-1:0]} + {1'b0, sub_n[NIB_W-1:0]}
                  + {{NIB_W{1'b0}}, 1'b1};
  assign res_o    = full_sum[DATA_W-1:0];

  always_comb begin
    flags_o          = '0;
    flags_o[FLAG_C]  = full_sum[DATA_W];
    flags_o[FLAG_DC] = nib_sum[NIB_W];
    flags_o[FLAG_Z]  = (res_o == '0);
    flags_o[FLAG_OV] = (min_i[DATA_W-1] ^ sub_i[DATA_W-1])
                     & (res_o[DATA_W-1] ^ min_i[DATA_W-1]);
    flags_o[FLAG_N]  = res_o[DATA_W-1];
  end
endmodule

// File: rtl/sub_regfile.sv
module sub_regfile
  import sub_exec_pkg::*;
#(
  parameter int PHYS_BANKS = 4,
  localparam int PIDX_W = (PHYS_BANKS > 1) ? $clog2(PHYS_BANKS) : 1,
  localparam int DEPTH  = PHYS_BANKS * (1 << DATA_W),
  localparam int PADDR_W = PIDX_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [PADDR_W-1:0] phys(input logic [ADDR_W-1:0] a);
    logic [PIDX_W-1:0] idx;
    if (PHYS_BANKS > 1) idx = a[DATA_W +: PIDX_W];
    else                idx = '0;
    return {idx, a[DATA_W-1:0]};
  endfunction

  always_ff @(posedge clk_i) begin
    if (we_i) mem[phys(waddr_i)] <= wdata_i;
  end

  assign rdata_a_o = mem[phys(raddr_a_i)];
  assign rdata_b_o = mem[phys(raddr_b_i)];
endmodule

// File: rtl/sub_exec_unit.sv
module sub_exec_unit
  import sub_exec_pkg::*;
#(
  parameter int PHYS_BANKS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [15:0]        instr_i,
  input  logic [3:0]         bsr_i,
  input  logic               w_we_i,
  input  logic [7:0]         w_wdata_i,
  input  logic               rf_we_i,
  input  logic [11:0]        rf_addr_i,
  input  logic [7:0]         rf_wdata_i,
  output logic [7:0]         rf_rdata_o,
  output logic [7:0]         w_o,
  output logic [4:0]         status_o,
  output logic [1:0]         phase_o
);
  phase_e            phase;
  dec_t              dec_now;
  dec_t              dec_q;
  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] res_q;
  logic [NFLAGS-1:0] flags_q;
  logic [DATA_W-1:0] w_q;
  logic [NFLAGS-1:0] status_q;
  logic [DATA_W-1:0] alu_res;
  logic [NFLAGS-1:0] alu_flags;
  logic [DATA_W-1:0] exec_rdata;
  logic              exec_any;
  logic              exec_to_w;
  logic              exec_to_f;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  sub_phase_gen u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase)
  );

  sub_decoder u_dec (
    .instr_i (instr_i),
    .bsr_i   (bsr_i),
    .dec_o   (dec_now)
  );

  // Q1: latch decoded word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= '{op: OP_NONE, to_file: 1'b0, addr: '0, lit: '0};
    end else if (phase == PH_DEC) begin
      dec_q <= dec_now;
    end
  end

  // Q2: operand read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) opnd_q <= '0;
    else if (phase == PH_READ) opnd_q <= (dec_q.op == OP_LIT) ? dec_q.lit : exec_rdata;
  end

  sub_alu u_alu (
    .min_i   (opnd_q),
    .sub_i   (w_q),
    .res_o   (alu_res),
    .flags_o (alu_flags)
  );

  // Q3: process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (phase == PH_PROC) begin
      res_q   <= alu_res;
      flags_q <= alu_flags;
    end
  end

  // Q4: write destination
  assign exec_any  = (phase == PH_WR) && (dec_q.op != OP_NONE);
  assign exec_to_f = exec_any && dec_q.to_file;
  assign exec_to_w = exec_any && !dec_q.to_file;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q      <= '0;
      status_q <= '0;
    end else begin
      if (exec_to_w)   w_q <= res_q;
      else if (w_we_i) w_q <= w_wdata_i;
      if (exec_any)    status_q <= flags_q;
    end
  end

  // execute write wins over host write
  assign mem_we    = exec_to_f || rf_we_i;
  assign mem_waddr = exec_to_f ? dec_q.addr : rf_addr_i;
  assign mem_wdata = exec_to_f ? res_q : rf_wdata_i;

  sub_regfile #(.PHYS_BANKS(PHYS_BANKS)) u_rf (
    .clk_i     (clk_i),
    .we_i      (mem_we),
    .waddr_i   (mem_waddr),
    .wdata_i   (mem_wdata),
    .raddr_a_i (dec_q.addr),
    .rdata_a_o (exec_rdata),
    .raddr_b_i (rf_addr_i),
    .rdata_b_o (rf_rdata_o)
  );

  assign w_o      = w_q;
  assign status_o = status_q;
  assign phase_o  = phase;
endmodule

// File: rtl/sub_exec_chk.sv
module sub_exec_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] phase_i,
  input logic [7:0] w_i,
  input logic [4:0] status_i,
  input logic       w_we_i,
  input logic       exec_any_i,
  input logic       exec_to_w_i,
  input logic       exec_to_f_i
);
  p_phase_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (phase_i == 2'($past(phase_i) + 2'd1)));

  p_status_wr_only_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_i) |-> ($past(phase_i) == 2'd3));

  p_nop_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'd3 && !exec_any_i) |=> $stable(status_i));

  p_n_is_msb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_to_w_i |=> (status_i[4] == w_i[7]));

  p_zero_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_to_w_i |=> (status_i[2] == (w_i == 8'h00)));

  p_w_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_to_f_i && !w_we_i) |=> $stable(w_i));
endmodule

bind sub_exec_unit sub_exec_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_i     (phase_o),
  .w_i         (w_o),
  .status_i    (status_o),
  .w_we_i      (w_we_i),
  .exec_any_i  (exec_any),
  .exec_to_w_i (exec_to_w),
  .exec_to_f_i (exec_to_f)
);

// File: tb/sub_exec_unit_test.sv
`timescale 1ns/1ps
module sub_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr_i = '0;
  logic [3:0]  bsr_i = '0;
  logic        w_we_i = 1'b0;
  logic [7:0]  w_wdata_i = '0;
  logic        rf_we_i = 1'b0;
  logic [11:0] rf_addr_i = '0;
  logic [7:0]  rf_wdata_i = '0;
  logic [7:0]  rf_rdata_o;
  logic [7:0]  w_o;
  logic [4:0]  status_o;
  logic [1:0]  phase_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sub_exec_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr_i), .bsr_i(bsr_i),
    .w_we_i(w_we_i), .w_wdata_i(w_wdata_i), .rf_we_i(rf_we_i),
    .rf_addr_i(rf_addr_i), .rf_wdata_i(rf_wdata_i), .rf_rdata_o(rf_rdata_o),
    .w_o(w_o), .status_o(status_o), .phase_o(phase_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference: {N,OV,Z,DC,C} and result of m - s
  function automatic logic [12:0] ref_sub(input logic [7:0] m, input logic [7:0] s);
    logic [7:0] r;
    int sd;
    logic c, dc, z, ov, n;
    r  = m - s;
    c  = (m >= s);
    dc = (m[3:0] >= s[3:0]);
    z  = (r == 8'h00);
    sd = int'($signed(m)) - int'($signed(s));
    ov = (sd < -128) || (sd > 127);
    n  = r[7];
    return {n, ov, z, dc, c, r};
  endfunction

  task automatic set_w(input logic [7:0] v);
    @(negedge clk); w_we_i = 1'b1; w_wdata_i = v;
    @(negedge clk); w_we_i = 1'b0;
  endtask

  task automatic mem_wr(input logic [11:0] a, input logic [7:0] v);
    @(negedge clk); rf_we_i = 1'b1; rf_addr_i = a; rf_wdata_i = v;
    @(negedge clk); rf_we_i = 1'b0;
  endtask

  task automatic mem_rd(input logic [11:0] a, output logic [7:0] v);
    rf_addr_i = a; #1; v = rf_rdata_o;
  endtask

  // issue one word at phase 0; returns W seen one phase before the write edge
  task automatic issue(input logic [15:0] iw, input logic [3:0] bank, output logic [7:0] w_early);
    @(negedge clk);
    while (phase_o != 2'd0) @(negedge clk);
    instr_i = iw; bsr_i = bank;
    @(negedge clk); instr_i = 16'h0000;
    @(negedge clk);
    @(negedge clk); w_early = w_o;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 w after reset", w_o, 0);
    check("R11 status after reset", status_o, 0);
    check("R1 phase after reset", phase_o, 0);
  endtask

  task automatic t_phase();
    logic [1:0] p0;
    @(negedge clk);
    p0 = phase_o;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check("R1 phase step", phase_o, (p0 + i) % 4);
    end
  endtask

  task automatic t_literal(input logic [7:0] k, input logic [7:0] w);
    logic [12:0] e;
    logic [7:0] early;
    set_w(w);
    e = ref_sub(k, w);
    issue({8'h08, k}, 4'h0, early);
    check("R12 w unchanged before write edge", early, w);
    check("R2 literal result", w_o, e[7:0]);
    check("R7 C", status_o[0], e[8]);
    check("R9 DC", status_o[1], e[9]);
    check("R7 Z", status_o[2], e[10]);
    check("R8 OV", status_o[3], e[11]);
    check("R8 N", status_o[4], e[12]);
  endtask

  task automatic t_reg(input logic [7:0] f, input bit d, input bit a,
                       input logic [3:0] bank, input logic [7:0] mval, input logic [7:0] w);
    logic [11:0] tgt, alt;
    logic [12:0] e;
    logic [7:0] early, v;
    if (a) tgt = {bank, f};
    else   tgt = (f >= 8'h80) ? {4'hF, f} : {4'h0, f};
    if (a) alt = (f >= 8'h80) ? {4'hF, f} : {4'h0, f};
    else   alt = {bank, f};
    mem_wr(alt, 8'h5A);
    mem_wr(tgt, mval);
    set_w(w);
    e = ref_sub(mval, w);
    issue({6'b010111, d, a, f}, bank, early);
    check("R7 R8 R9 flags reg form", status_o, int'(e[12:8]));
    if (d) begin
      mem_rd(tgt, v);
      check("R4 file written", v, e[7:0]);
      check("R4 w kept", w_o, w);
    end else begin
      mem_rd(tgt, v);
      check("R3 file kept", v, mval);
      check("R3 w result", w_o, e[7:0]);
    end
    mem_rd(alt, v);
    if (a) check("R6 bank reg addressing", v, 8'h5A);
    else   check("R5 access addressing", v, 8'h5A);
  endtask

  task automatic t_nop(input logic [15:0] iw);
    logic [7:0] early, v;
    logic [4:0] st;
    mem_wr(12'h033, 8'hC3);
    set_w(8'h3C);
    st = status_o;
    issue(iw, 4'h0, early);
    check("R10 w unchanged", w_o, 8'h3C);
    check("R10 status unchanged", status_o, st);
    mem_rd(12'h033, v);
    check("R10 memory unchanged", v, 8'hC3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_phase();
    t_literal(8'h02, 8'h01);   // positive
    t_literal(8'h02, 8'h02);   // zero
    t_literal(8'h01, 8'h02);   // negative 0xFF
    t_literal(8'h10, 8'h01);   // nibble borrow
    t_literal(8'h80, 8'h01);   // signed overflow
    t_literal(8'h7F, 8'hFF);   // overflow other way
    t_reg(8'h20, 1'b0, 1'b0, 4'h2, 8'h03, 8'h02);
    t_reg(8'h85, 1'b1, 1'b0, 4'h1, 8'h02, 8'h02);
    t_reg(8'h85, 1'b1, 1'b1, 4'h2, 8'h01, 8'h02);
    t_reg(8'h10, 1'b0, 1'b1, 4'h1, 8'h91, 8'h12);
    t_reg(8'h40, 1'b1, 1'b1, 4'h2, 8'h00, 8'h80);
    t_nop(16'h1234);
    t_nop(16'h0C55);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule